// File: doc/BRIEF.md
# Tuner Reference Divider and Phase Detector Control

This block sits between the crystal oscillator and the analog charge pump of a synthesizer loop for a tuner. It divides the crystal clock (nominally 3.2 or 4.0 MHz) by one of two power-of-two ratios to form the comparison frequency. A digital three-state phase/frequency detector compares that reference against the pulse from the programmable loop divider and produces up and down pump enables. The analog pump and the tuning amplifier lie outside this block. The block only drives their enables and selects.

A seven-bit control word sets several things: the reference ratio, a forced pump mode (normal detection, high impedance, up source only or down source only), the pump current select, the tuning-amplifier shutdown and a test mode. The test mode routes the reference clock and the divider half-rate clock onto two band outputs. The control word is sampled only at the edge that closes a reference period, so a setting change never cuts a pump pulse short. Five band bits drive active-low band-switch outputs.

The loop-divider pulse `div_pulse` is a one-cycle strobe and `div_half` is a level. Both are synchronous to `clk`.

Top module: `ref_pfd_ctrl`

## Requirements
- R1: `ctrl_word` bit positions are [6]=pump current, [5]=test route, [4]=mode B, [3]=ratio B, [2]=ratio A, [1]=mode A, [0]=amplifier off. The reference period is 2^REF_LOG2 clock cycles (512 by default) when ratio A equals ratio B, and twice that when they differ.
- R2: A new `ctrl_word` is captured only at the clock edge that ends a reference period, and has no effect on any output before that edge.
- R3: In normal mode (mode A=1, mode B=0), a reference event raises `pump_up` and a divider event raises `pump_dn`, each one edge after the event. Either one stays high alone until the other event arrives.
- R4: Once both `pump_up` and `pump_dn` are high, both stay high for exactly RST_DLY cycles and then fall together.
- R5: Mode A=1,B=1 drives both pump enables low. Mode A=0,B=0 holds `pump_up` high and `pump_dn` low. Mode A=0,B=1 holds `pump_dn` high and `pump_up` low. The detector state is cleared while a forced mode is active.
- R6: `pump_hi` follows the latched pump-current bit and `amp_off` follows the latched amplifier-off bit.
- R7: `band_bits` index order is [4]=B7, [3]=B4, [2]=B2, [1]=B1, [0]=B0. One edge after `band_bits` is applied, each `band_n` bit is the inverse of its band bit (low = switch on).
- R8: With the test route latched, a B7 or B2 band bit of 0 makes `band_n[4]` carry the reference clock and `band_n[2]` carry `div_half` delayed by one edge. A band bit of 1 still forces its output low.
- R9: During reset, `band_n` is all ones, all pump outputs and `amp_off` are low, the mode is normal and the ratio is the short one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | crystal clock |
| rst_n | input | 1 | asynchronous active-low reset |
| div_pulse | input | 1 | one-cycle strobe from the loop divider |
| div_half | input | 1 | loop divider output divided by two |
| ctrl_word | input | 7 | control word, bit map in R1 |
| band_bits | input | 5 | band switch bits, order in R7 |
| pump_up | output | 1 | enable for the upper (source) pump |
| pump_dn | output | 1 | enable for the lower (sink) pump |
| pump_hi | output | 1 | high pump current select |
| amp_off | output | 1 | tuning amplifier shutdown |
| band_n | output | 5 | active-low band switch drive levels |

## Verification
The band outputs and the routed `div_half` copy are due one edge after their inputs change, so each is sampled at the next falling edge. A reference event shows on `pump_up` one edge after the period ends. The bench uses that rising edge as a phase marker and writes a new control word at the same falling edge. It then expects the old settings to hold for exactly the period length minus one samples and the new ones to appear at the sample that follows. The overlap window of the detector is measured by counting falling-edge samples with both enables high. Reference ratios are measured as the spacing between successive rises of the routed reference in test mode.

// File: rtl/ref_pfd_pkg.sv
package ref_pfd_pkg;

    typedef enum logic [1:0] {
        PMP_NORMAL,
        PMP_HIZ,
        PMP_UP,
        PMP_DN
    } pump_mode_e;

    typedef struct packed {
        logic pump_hi;
        logic test_route;
        logic mode_b;
        logic ratio_b;
        logic ratio_a;
        logic mode_a;
        logic amp_off;
    } ctrl_word_t;

    localparam int BAND_W = 5;
    localparam int IDX_B7 = 4;
    localparam int IDX_B2 = 2;

    function automatic pump_mode_e decode_mode(input logic mode_a, input logic mode_b);
        pump_mode_e m;
        case ({mode_a, mode_b})
            2'b10:   m = PMP_NORMAL;
            2'b11:   m = PMP_HIZ;
            2'b00:   m = PMP_UP;
            default: m = PMP_DN;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/ref_divider.sv
module ref_divider #(
    parameter int REF_LOG2 = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ratio_long,
    output logic ref_tick,
    output logic ref_level
);
    localparam int CW = REF_LOG2 + 1;
    localparam logic [CW-1:0] LAST_SHORT = {1'b0, {REF_LOG2{1'b1}}};
    localparam logic [CW-1:0] LAST_LONG  = {CW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [CW-1:0] last_idx;

    always_comb begin
        last_idx  = ratio_long ? LAST_LONG : LAST_SHORT;
        ref_tick  = (st_q.cnt == last_idx);
        ref_level = ratio_long ? st_q.cnt[REF_LOG2] : st_q.cnt[REF_LOG2-1];
        st_d      = st_q;
        if (ref_tick) st_d.cnt = '0;
        else          st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> (st_q.cnt == '0)); // R1
    AST_SHORT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !ratio_long |-> (st_q.cnt <= LAST_SHORT)); // R1

endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
    parameter int RST_DLY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic ref_evt,
    input  logic div_evt,
    output logic up,
    output logic dn
);
    localparam int DW = $clog2(RST_DLY + 1);
    localparam logic [DW-1:0] HOLD_LAST = DW'(RST_DLY - 1);

    typedef struct packed {
        logic          up;
        logic          dn;
        logic [DW-1:0] hold;
    } pfd_state_t;

    pfd_state_t st_d, st_q;
    logic both, release_now;

    always_comb begin
        both        = st_q.up & st_q.dn;
        release_now = both && (st_q.hold == HOLD_LAST);
        st_d.up     = ref_evt | (st_q.up & ~release_now);
        st_d.dn     = div_evt | (st_q.dn & ~release_now);
        st_d.hold   = (both && !release_now) ? st_q.hold + 1'b1 : '0;
        if (!enable) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign up = st_q.up;
    assign dn = st_q.dn;

    AST_OVERLAP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && both && st_q.hold == HOLD_LAST && !ref_evt && !div_evt) |=> (!st_q.up && !st_q.dn)); // R4
    AST_FORCED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!st_q.up && !st_q.dn)); // R5

endmodule

// File: rtl/band_drive.sv
module band_drive
    import ref_pfd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BAND_W-1:0] band_in,
    input  logic              test_en,
    input  logic              ref_level,
    input  logic              div_half,
    output logic [BAND_W-1:0] band_n
);
    typedef struct packed {
        logic [BAND_W-1:0] bits;
        logic              half;
    } band_state_t;

    band_state_t st_d, st_q;

    always_comb begin
        st_d.bits = band_in;
        st_d.half = div_half;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < BAND_W; i++) begin : g_bit
        if (i == IDX_B7) begin : g_ref
            assign band_n[i] = st_q.bits[i] ? 1'b0 : (test_en ? ref_level : 1'b1);
        end else if (i == IDX_B2) begin : g_half
            assign band_n[i] = st_q.bits[i] ? 1'b0 : (test_en ? st_q.half : 1'b1);
        end else begin : g_plain
            assign band_n[i] = ~st_q.bits[i];
        end
    end

    AST_PLAIN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({band_n[3], band_n[1], band_n[0]} == ~$past({band_in[3], band_in[1], band_in[0]}))); // R7

endmodule

// File: rtl/ref_pfd_ctrl.sv
module ref_pfd_ctrl
    import ref_pfd_pkg::*;
#(
    parameter int REF_LOG2 = 9,
    parameter int RST_DLY  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       div_pulse,
    input  logic       div_half,
    input  logic [6:0] ctrl_word,
    input  logic [4:0] band_bits,
    output logic       pump_up,
    output logic       pump_dn,
    output logic       pump_hi,
    output logic       amp_off,
    output logic [4:0] band_n
);
    localparam ctrl_word_t CTRL_RESET = ctrl_word_t'(7'b0000010);

    typedef struct packed {
        ctrl_word_t ctrl;
    } top_state_t;

    top_state_t st_d, st_q;
    logic       ref_tick, ref_level, ratio_long;
    logic       det_up, det_dn;
    pump_mode_e mode;

    always_comb begin
        st_d = st_q;
        if (ref_tick) st_d.ctrl = ctrl_word_t'(ctrl_word);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.ctrl <= CTRL_RESET;
        else        st_q <= st_d;
    end

    always_comb begin
        ratio_long = st_q.ctrl.ratio_a ^ st_q.ctrl.ratio_b;
        mode       = decode_mode(st_q.ctrl.mode_a, st_q.ctrl.mode_b);
        pump_hi    = st_q.ctrl.pump_hi;
        amp_off    = st_q.ctrl.amp_off;
        case (mode)
            PMP_NORMAL: begin pump_up = det_up; pump_dn = det_dn; end
            PMP_UP:     begin pump_up = 1'b1;   pump_dn = 1'b0;   end
            PMP_DN:     begin pump_up = 1'b0;   pump_dn = 1'b1;   end
            default:    begin pump_up = 1'b0;   pump_dn = 1'b0;   end
        endcase
    end

    ref_divider #(.REF_LOG2(REF_LOG2)) i_ref_divider (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_long (ratio_long),
        .ref_tick   (ref_tick),
        .ref_level  (ref_level)
    );

    pfd_core #(.RST_DLY(RST_DLY)) i_pfd_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (mode == PMP_NORMAL),
        .ref_evt (ref_tick),
        .div_evt (div_pulse),
        .up      (det_up),
        .dn      (det_dn)
    );

    band_drive i_band_drive (
        .clk       (clk),
        .rst_n     (rst_n),
        .band_in   (band_bits),
        .test_en   (st_q.ctrl.test_route),
        .ref_level (ref_level),
        .div_half  (div_half),
        .band_n    (band_n)
    );

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_tick |=> $stable(st_q.ctrl)); // R2
    AST_PUMP_EXCLUSIVE_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != PMP_NORMAL) |-> !(pump_up && pump_dn)); // R5

endmodule

// File: tb/test_ref_pfd_ctrl.sv
module test_ref_pfd_ctrl;
    localparam int L   = 3;
    localparam int DLY = 2;
    localparam int RS  = 1 << L;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_pulse = 1'b0;
    logic       div_half = 1'b0;
    logic [6:0] ctrl_word = 7'b0000010;
    logic [4:0] band_bits = 5'b0;
    logic       pump_up, pump_dn, pump_hi, amp_off;
    logic [4:0] band_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ref_pfd_ctrl #(.REF_LOG2(L), .RST_DLY(DLY)) i_ref_pfd_ctrl (
        .clk(clk), .rst_n(rst_n), .div_pulse(div_pulse), .div_half(div_half),
        .ctrl_word(ctrl_word), .band_bits(band_bits),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_hi(pump_hi), .amp_off(amp_off),
        .band_n(band_n)
    );

    function automatic logic [6:0] cw(input logic t14, input logic t13, input logic t12,
                                      input logic t11, input logic t10, input logic t9,
                                      input logic t8);
        return {t14, t13, t12, t11, t10, t9, t8};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sync_rise();
        @(negedge clk);
        while (pump_up || pump_dn) begin
            if (pump_up && !pump_dn) begin
                div_pulse = 1'b1;
                @(negedge clk);
                div_pulse = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        while (!pump_up) @(negedge clk);
    endtask

    task automatic b7_period(output int p);
        logic prev;
        p = 0;
        prev = band_n[4];
        @(negedge clk);
        while (!((!prev) && band_n[4])) begin prev = band_n[4]; @(negedge clk); end
        prev = band_n[4];
        @(negedge clk);
        p = 1;
        while (!((!prev) && band_n[4])) begin prev = band_n[4]; @(negedge clk); p++; end
    endtask

    initial begin : watchdog
        #1000000;
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        int n;
        int p;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(band_n == 5'h1F, "R9 band_n", band_n, 31);
        chk({pump_up, pump_dn, pump_hi, amp_off} == 4'b0, "R9 pumps", {pump_up, pump_dn, pump_hi, amp_off}, 0);
        rst_n = 1'b1;

        // R7 exhaustive band sweep
        for (int b = 0; b < 32; b++) begin
            band_bits = 5'(b);
            @(negedge clk);
            chk(band_n == ~5'(b), "R7 band", band_n, 31 - b);
        end
        band_bits = 5'b0;

        // R3 reference leads, R4 overlap window
        sync_rise();
        chk(pump_up && !pump_dn, "R3 up alone", {pump_up, pump_dn}, 2);
        repeat (2) begin
            @(negedge clk);
            chk(pump_up && !pump_dn, "R3 up held", {pump_up, pump_dn}, 2);
        end
        div_pulse = 1'b1;
        @(negedge clk);
        div_pulse = 1'b0;
        n = 0;
        while (pump_up && pump_dn) begin n++; @(negedge clk); end
        chk(n == DLY, "R4 overlap ref-lead", n, DLY);
        chk(!pump_up && !pump_dn, "R4 fall together", {pump_up, pump_dn}, 0);

        // R3 divider leads
        div_pulse = 1'b1;
        @(negedge clk);
        div_pulse = 1'b0;
        chk(pump_dn && !pump_up, "R3 dn alone", {pump_up, pump_dn}, 1);
        while (!pump_up) @(negedge clk);
        n = 0;
        while (pump_up && pump_dn) begin n++; @(negedge clk); end
        chk(n == DLY, "R4 overlap div-lead", n, DLY);
        chk(!pump_up && !pump_dn, "R4 fall together div-lead", {pump_up, pump_dn}, 0);

        // R2 / R6 capture timing
        sync_rise();
        ctrl_word = cw(1, 0, 0, 0, 0, 1, 1);
        div_pulse = 1'b1;
        for (int j = 1; j < RS; j++) begin
            @(negedge clk);
            div_pulse = 1'b0;
            chk(!pump_hi && !amp_off, "R2 old settings held", {pump_hi, amp_off}, 0);
        end
        @(negedge clk);
        chk(pump_hi && amp_off, "R6 new settings", {pump_hi, amp_off}, 3);

        // R5 forced modes
        for (int m = 0; m < 3; m++) begin
            logic eu, ed;
            sync_rise();
            case (m)
                0: begin ctrl_word = cw(0, 0, 1, 0, 0, 1, 0); eu = 0; ed = 0; end
                1: begin ctrl_word = cw(0, 0, 0, 0, 0, 0, 0); eu = 1; ed = 0; end
                default: begin ctrl_word = cw(0, 0, 1, 0, 0, 0, 0); eu = 0; ed = 1; end
            endcase
            div_pulse = 1'b1;
            for (int j = 1; j < RS; j++) begin
                @(negedge clk);
                div_pulse = 1'b0;
            end
            chk(!pump_up && !pump_dn, "R2 mode not yet applied", {pump_up, pump_dn}, 0);
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (k == 2) div_pulse = 1'b1;
                if (k == 3) div_pulse = 1'b0;
                chk(pump_up == eu && pump_dn == ed, "R5 forced mode", {pump_up, pump_dn}, {eu, ed});
            end
            div_pulse = 1'b0;
            ctrl_word = cw(0, 0, 0, 0, 0, 1, 0);
            repeat (2 * RS + 2) @(negedge clk);
        end

        // R1 / R8 reference ratio through the routed output
        for (int r = 0; r < 4; r++) begin
            logic t11, t10;
            t11 = r[1];
            t10 = r[0];
            ctrl_word = cw(0, 1, 0, t11, t10, 1, 0);
            repeat (4 * RS + 4) @(negedge clk);
            b7_period(p);
            chk(p == ((t11 == t10) ? RS : 2 * RS), "R1 reference period", p, (t11 == t10) ? RS : 2 * RS);
        end

        // R8 routed divider half-rate copy and override by band bit
        for (int k = 0; k < 6; k++) begin
            logic v;
            v = (k == 0 || k == 2 || k == 3);
            div_half = v;
            @(negedge clk);
            chk(band_n[2] == v, "R8 div_half on B2", band_n[2], v);
        end
        band_bits = 5'b10111;
        @(negedge clk);
        for (int k = 0; k < 2 * RS; k++) begin
            @(negedge clk);
            if (k == 3) div_half = ~div_half;
            chk(band_n == 5'b01000, "R8 band bit overrides test", band_n, 8);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule